// File: doc/BRIEF.md
# Dual-Clock Down Timer with Gated and Edge Input

This block is a down-counting timer for a small microcontroller. It runs from the system clock and is paced by two oscillator strobes. In run and wait modes, twelve main-oscillator strobes make one internal tick. In stop mode, twelve standby-oscillator strobes make one tick, so the timer keeps running while the core sleeps. A selectable power-of-two prescaler of up to 128 feeds an 8-bit down counter. Loading 0 counts 256 steps, so the longest interval is 12 × 2^15 oscillator periods.

There are two further modes besides internal ticking. Edge mode counts rising edges of an external input. Gated mode counts internal ticks only while that input is high, which makes it possible to measure a gate pulse from an oscillator-measurement circuit. A select bit chooses the input source: the external pin, or the oscillator-measurement gate. Both sources pass through a two-flop synchroniser.

When the counter reaches zero, the block raises a level interrupt that stays high until software clears it. In stop mode, the interrupt also drives a wake request. The counter never reloads by itself. Software reaches the block through a small register interface with a write strobe and a combinational read port.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, every readable register (count at address 0, control at 1, status at 2, prescaler at 3) reads 0, and both `irq` and `wake_req` are low.
- R2: With `stop_mode` low and control mode 01 (internal tick), one tick occurs every 12 `main_pulse` strobes, counted from the count load. With prescale 0, loading N>0 raises `irq` exactly 12·N strobes after the load.
- R3: With `stop_mode` high, ticks come from `sby_pulse` strobes (12 per tick) and `main_pulse` has no effect on the count.
- R4: Control bits [4:2] hold the prescale exponent p. The counter decrements once every 2^p counted events. The prescaler reads back at address 3.
- R5: A load value of 0 counts 256 steps before terminal count. With p=7 the interval is 12·128·256 strobes.
- R6: The counter moving from 1 to 0 sets `irq` (status bit 0). `irq` stays high until software writes 1 to status bit 0. Writing 0 there leaves it unchanged.
- R7: After terminal count the counter stays at 0, with no reload and no further interrupt, until software writes the count register again.
- R8: `wake_req` is high exactly when `irq` is high and `stop_mode` is high.
- R9: Control mode 10 (edge) decrements once per rising edge of the selected input. The decrement lands on the third clock edge after the input rises, because the input first passes a two-flop synchroniser.
- R10: Control mode 11 (gated) counts internal ticks only while the synchronised selected input is high.
- R11: Control bit 5 picks the input source: 0 selects `ext_pin` and 1 selects `osc_gate`. The source that is not selected has no effect.
- R12: Control mode 00 halts counting. A loaded value then holds regardless of strobes or input activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_pulse | input | 1 | One-cycle strobe per main-oscillator period |
| sby_pulse | input | 1 | One-cycle strobe per standby-oscillator period |
| stop_mode | input | 1 | CPU is in stop mode; selects the standby strobe |
| ext_pin | input | 1 | Asynchronous external timer input |
| osc_gate | input | 1 | Asynchronous gate from oscillator-measurement logic |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Level interrupt, held until cleared |
| wake_req | output | 1 | Request to leave stop mode |

## Verification
The hardest case to reach from the ports is gated mode. Here, whether a tick counts depends on where the synchronised gate level lies against the free-running divide-by-12 phase, and neither is visible directly. The stimulus pins down the phase by loading the count, since a load restarts the divider. It then raises and lowers the gate on chosen cycles, so that the synchroniser delay puts exactly two tick instants inside the window and leaves the next one outside it. The edge mode test in the same way steps the input and samples the count one cycle before and at the third edge, which exposes the synchroniser depth.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_HALT = 2'b00,
        MODE_INT  = 2'b01,
        MODE_EDGE = 2'b10,
        MODE_GATE = 2'b11
    } tmr_mode_e;

    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_PRE  = 2'd3;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_tick_div.sv
module tmr_tick_div #(
    parameter int DIV_N = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pulse,
    output logic tick
);
    localparam int DIV_W = $clog2(DIV_N);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_N - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (clr) begin
            div_d = '0;
        end else if (pulse) begin
            div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick = pulse & (div_q == LAST) & ~clr;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 7,
    parameter int PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             evt,
    input  logic [PS_W-1:0]  ps,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [PRE_W-1:0] pre,
    output logic             armed,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
        logic             armed;
        logic             irq;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [PRE_W-1:0] lim;
    logic             term;

    always_comb begin
        lim  = ~({PRE_W{1'b1}} << ps);
        term = 1'b0;
        st_d = st_q;
        if (load) begin
            st_d.cnt   = load_val;
            st_d.pre   = '0;
            st_d.armed = 1'b1;
        end else if (evt && st_q.armed) begin
            if (st_q.pre >= lim) begin
                st_d.pre = '0;
                st_d.cnt = st_q.cnt - 1'b1;
                if (st_q.cnt == CNT_W'(1)) begin
                    st_d.armed = 1'b0;
                    term       = 1'b1;
                end
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
        if (irq_clr) st_d.irq = 1'b0;
        if (term)    st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt   = st_q.cnt;
    assign pre   = st_q.pre;
    assign armed = st_q.armed;
    assign irq   = st_q.irq;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PRE_W     = 7,
    parameter int DIV_N     = 12,
    parameter int SYNC_STG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_pulse,
    input  logic             sby_pulse,
    input  logic             stop_mode,
    input  logic             ext_pin,
    input  logic             osc_gate,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq,
    output logic             wake_req
);
    localparam int PS_W   = $clog2(PRE_W + 1);
    localparam int SRC_B  = 2 + PS_W;
    localparam int CTRL_W = SRC_B + 1;

    typedef struct packed {
        logic             src;
        logic [PS_W-1:0]  ps;
        tmr_mode_e        mode;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic             load, irq_clr;
    logic             osc_pulse, tick;
    logic             in_sel, in_level, in_rise;
    logic             evt;
    logic [CNT_W-1:0] cnt_w;
    logic [PRE_W-1:0] pre_w;
    logic             armed_w;
    logic             irq_w;
    tmr_mode_e        mode_w;

    // register writes
    always_comb begin
        load    = wr_en && (wr_addr == ADDR_CNT);
        irq_clr = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];
        ctrl_d  = ctrl_q;
        if (wr_en && (wr_addr == ADDR_CTRL)) begin
            ctrl_d.mode = tmr_mode_e'(wr_data[1:0]);
            ctrl_d.ps   = wr_data[2 +: PS_W];
            ctrl_d.src  = wr_data[SRC_B];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{src: 1'b0, ps: '0, mode: MODE_HALT};
        else        ctrl_q <= ctrl_d;
    end

    assign mode_w    = ctrl_q.mode;
    assign osc_pulse = stop_mode ? sby_pulse : main_pulse;
    assign in_sel    = ctrl_q.src ? osc_gate : ext_pin;

    tmr_tick_div #(.DIV_N(DIV_N)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .pulse (osc_pulse),
        .tick  (tick)
    );

    tmr_sync_edge #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (in_sel),
        .level (in_level),
        .rise  (in_rise)
    );

    always_comb begin
        unique case (ctrl_q.mode)
            MODE_INT:  evt = tick;
            MODE_EDGE: evt = in_rise;
            MODE_GATE: evt = tick & in_level;
            default:   evt = 1'b0;
        endcase
    end

    tmr_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PS_W(PS_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (wr_data),
        .evt      (evt),
        .ps       (ctrl_q.ps),
        .irq_clr  (irq_clr),
        .cnt      (cnt_w),
        .pre      (pre_w),
        .armed    (armed_w),
        .irq      (irq_w)
    );

    always_comb begin
        unique case (rd_addr)
            ADDR_CNT:  rd_data = cnt_w;
            ADDR_CTRL: rd_data = CNT_W'(CTRL_W'(ctrl_q));
            ADDR_STAT: rd_data = CNT_W'(irq_w);
            default:   rd_data = CNT_W'(pre_w);
        endcase
    end

    assign irq      = irq_w;
    assign wake_req = irq_w & stop_mode;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             stop_mode,
    input logic             irq,
    input logic             wake_req,
    input tmr_mode_e        mode,
    input logic [CNT_W-1:0] cnt,
    input logic             armed
);
    logic ld, clr;
    assign ld  = wr_en && (wr_addr == ADDR_CNT);
    assign clr = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq); // R6
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cnt) == CNT_W'(1) && cnt == '0)); // R6
    AST_WAKE_ONLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (irq && stop_mode)); // R8
    AST_WAKE_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && stop_mode) |-> wake_req); // R8
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !ld) |=> (!armed && cnt == '0)); // R7
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALT && !ld) |=> $stable(cnt)); // R12
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) - 1'b1))); // R4
endmodule

bind dual_tick_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .stop_mode (stop_mode),
    .irq       (irq),
    .wake_req  (wake_req),
    .mode      (mode_w),
    .cnt       (cnt_w),
    .armed     (armed_w)
);

// File: tb/test_dual_tick_timer.sv
module test_dual_tick_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_pulse = 1'b1;
    logic       sby_pulse = 1'b0;
    logic       stop_mode = 1'b0;
    logic       ext_pin = 1'b0;
    logic       osc_gate = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       irq, wake_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    dual_tick_timer i_dual_tick_timer (
        .clk(clk), .rst_n(rst_n), .main_pulse(main_pulse), .sby_pulse(sby_pulse),
        .stop_mode(stop_mode), .ext_pin(ext_pin), .osc_gate(osc_gate),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wake_req(wake_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ctrl: [1:0] mode 00 halt/01 int/10 edge/11 gated, [4:2] ps, [5] src
    function automatic logic [7:0] ctl(input int mode, input int ps, input int src);
        return 8'(mode | (ps << 2) | (src << 5));
    endfunction

    task automatic t_reset;
        int v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reg", v, 0);
        end
        check("R1 irq", int'(irq), 0);
        check("R1 wake", int'(wake_req), 0);
    endtask

    task automatic t_run_div;
        int v;
        wr(2'd1, ctl(1, 0, 0));
        wr(2'd0, 8'd3);
        wait_n(12);
        rd(2'd0, v);
        check("R2 first step", v, 2);
        wait_n(23);
        check("R2 irq early", int'(irq), 0);
        wait_n(1);
        check("R2 irq at 36", int'(irq), 1);
        rd(2'd2, v);
        check("R6 status bit", v, 1);
        wr(2'd2, 8'd0);
        check("R6 write 0 keeps", int'(irq), 1);
        wait_n(200);
        rd(2'd0, v);
        check("R7 no reload cnt", v, 0);
        check("R7 irq held", int'(irq), 1);
        wr(2'd2, 8'd1);
        check("R6 cleared", int'(irq), 0);
        wait_n(100);
        check("R7 no second irq", int'(irq), 0);
    endtask

    task automatic t_prescale;
        int v;
        wr(2'd1, ctl(1, 2, 0));
        wr(2'd0, 8'd2);
        wait_n(36);
        rd(2'd3, v);
        check("R4 prescaler value", v, 3);
        wait_n(12);
        rd(2'd0, v);
        check("R4 step at 48", v, 1);
        wait_n(47);
        check("R4 irq early", int'(irq), 0);
        wait_n(1);
        check("R4 irq at 96", int'(irq), 1);
        wr(2'd2, 8'd1);
    endtask

    task automatic t_max;
        int v;
        wr(2'd1, ctl(1, 0, 0));
        wr(2'd0, 8'd0);
        wait_n(12);
        rd(2'd0, v);
        check("R5 wrap to 255", v, 255);
        wait_n(3059);
        check("R5 irq early", int'(irq), 0);
        wait_n(1);
        check("R5 irq at 3072", int'(irq), 1);
        wr(2'd2, 8'd1);
        wr(2'd1, ctl(1, 7, 0));
        wr(2'd0, 8'd1);
        wait_n(1535);
        check("R5 ps7 early", int'(irq), 0);
        wait_n(1);
        check("R5 ps7 at 1536", int'(irq), 1);
        wr(2'd2, 8'd1);
    endtask

    task automatic t_stop;
        int v;
        stop_mode = 1'b1;
        wr(2'd1, ctl(1, 0, 0));
        wr(2'd0, 8'd2);
        wait_n(100);
        rd(2'd0, v);
        check("R3 main ignored", v, 2);
        sby_pulse = 1'b1;
        wait_n(23);
        check("R3 irq early", int'(irq), 0);
        check("R8 no wake yet", int'(wake_req), 0);
        wait_n(1);
        check("R3 irq at 24", int'(irq), 1);
        check("R8 wake in stop", int'(wake_req), 1);
        sby_pulse = 1'b0;
        stop_mode = 1'b0;
        #1;
        check("R8 no wake in run", int'(wake_req), 0);
        check("R8 irq kept", int'(irq), 1);
        wr(2'd2, 8'd1);
    endtask

    task automatic pulse_in(input bit use_osc);
        @(negedge clk);
        if (use_osc) osc_gate = 1'b1; else ext_pin = 1'b1;
        wait_n(3);
        if (use_osc) osc_gate = 1'b0; else ext_pin = 1'b0;
        wait_n(3);
    endtask

    task automatic t_edge;
        int v;
        wr(2'd1, ctl(2, 0, 0));
        wr(2'd0, 8'd2);
        ext_pin = 1'b1;
        wait_n(2);
        rd(2'd0, v);
        check("R9 sync latency", v, 2);
        wait_n(1);
        rd(2'd0, v);
        check("R9 edge counted", v, 1);
        wait_n(20);
        rd(2'd0, v);
        check("R9 level not counted", v, 1);
        ext_pin = 1'b0;
        wait_n(3);
        pulse_in(1'b0);
        check("R9 irq on 2nd edge", int'(irq), 1);
        wr(2'd2, 8'd1);
    endtask

    task automatic t_src;
        int v;
        wr(2'd1, ctl(2, 0, 1));
        wr(2'd0, 8'd2);
        pulse_in(1'b0);
        pulse_in(1'b0);
        rd(2'd0, v);
        check("R11 pin ignored", v, 2);
        pulse_in(1'b1);
        rd(2'd0, v);
        check("R11 osc gate counted", v, 1);
    endtask

    task automatic t_gate;
        int v;
        wr(2'd1, ctl(3, 0, 0));
        wr(2'd0, 8'd3);
        ext_pin = 1'b1;
        wait_n(30);
        ext_pin = 1'b0;
        wait_n(30);
        rd(2'd0, v);
        check("R10 two ticks in window", v, 1);
        wait_n(60);
        rd(2'd0, v);
        check("R10 gate low holds", v, 1);
        ext_pin = 1'b1;
        wait_n(40);
        ext_pin = 1'b0;
        rd(2'd0, v);
        check("R10 finish", v, 0);
        check("R10 irq", int'(irq), 1);
        wr(2'd2, 8'd1);
    endtask

    task automatic t_halt;
        int v;
        wr(2'd1, ctl(0, 0, 0));
        wr(2'd0, 8'd2);
        sby_pulse = 1'b1;
        wait_n(50);
        pulse_in(1'b0);
        sby_pulse = 1'b0;
        wait_n(50);
        rd(2'd0, v);
        check("R12 halted", v, 2);
        rd(2'd1, v);
        check("R12 ctrl readback", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        t_reset();
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_run_div();
        t_prescale();
        t_max();
        t_stop();
        t_edge();
        t_src();
        t_gate();
        t_halt();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule